// File: doc/BRIEF.md
# Processor sleep and wake controller

This block decides when a processor core halts instruction fetch and when it resumes. It watches decode strobes for three instructions: wait-for-interrupt, wait-for-event and send-event. It also watches a strobe for an exception return that lands in thread mode. From these it raises a registered sleep flag that gates fetch. While the core sleeps, it checks the interrupt pending, enable and priority state against the current execution priority. When the wake rule for the current kind of sleep is met, it drops the flag and pulses a wake output for one cycle.

A hidden one-bit event latch links send-event to wait-for-event. An event that is recorded while the core runs makes the next wait-for-event fall through without sleeping, and that wait-for-event consumes the event. Two configuration inputs change the behaviour. The first makes the core return to sleep after a handler hands control back to thread mode. The second turns every newly raised pending bit into an event, whatever its enable or priority, so that a wait-for-event sleep can end without a handler being taken. A separate take-exception output tells the core when a handler may be entered. A global mask can hold that entry back after the core has woken.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, sleep_o, wake_o and take_exc_o are 0 and the event latch is clear, so the first wait-for-event (wfe_i) enters sleep.
- R2: A wfi_i strobe while awake sets sleep_o in the next cycle, and sleep_o stays 1 as long as no interrupt qualifies.
- R3: An interrupt qualifies when its pending and enable bits are both 1 and its priority value is numerically below exec_prio_i (lower value means more urgent). From wait-for-interrupt sleep only a qualifying interrupt wakes the core. sleep_o falls in the cycle after the interrupt is seen, and wake_o is 1 in that same cycle and 0 in the next. Disabled or low-urgency interrupts leave the core asleep, even when send_ev_on_pend_i is 1.
- R4: take_exc_o is 1 only while the core is awake, an interrupt qualifies and mask_i is 0. With mask_i at 1 a qualifying interrupt still wakes the core, but take_exc_o stays 0 until mask_i goes to 0.
- R5: sev_i sets the event latch. A later wfe_i with the latch set does not sleep and clears the latch, so the wfe_i after it sleeps.
- R6: A wfe_i with the latch clear sets sleep_o in the next cycle. A qualifying interrupt ends that sleep with the same timing as in R3.
- R7: With send_ev_on_pend_i at 1, a 0-to-1 change of any irq_pend_i bit wakes a wait-for-event sleep in the next cycle, even when that interrupt is disabled or not urgent enough. A bit that was already 1 before the sleep does not wake the core, and with send_ev_on_pend_i at 0 a new pending bit does not wake it.
- R8: An event that arrives in the same cycle as a wfe_i that consumes the latch leaves the latch set, so the next wfe_i also falls through.
- R9: An event that arrives in the same cycle as a wfe_i that finds the latch clear is not lost. sleep_o is 1 for exactly one cycle, then falls with a wake_o pulse, and the event is consumed.
- R10: An exit strobe (exc_ret_thread_i) enters sleep in the next cycle only when sleep_on_exit_i is 1. That sleep follows the wait-for-interrupt wake rule.
- R11: Waking from a wait-for-event sleep clears the event latch, so the next wfe_i sleeps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt decode strobe |
| wfe_i | input | 1 | Wait-for-event decode strobe |
| sev_i | input | 1 | Send-event decode strobe |
| exc_ret_thread_i | input | 1 | Handler return to thread mode strobe |
| sleep_on_exit_i | input | 1 | Enables sleep after a handler returns |
| send_ev_on_pend_i | input | 1 | Makes each newly pending interrupt an event |
| irq_pend_i | input | NIRQ | Interrupt pending bits |
| irq_en_i | input | NIRQ | Interrupt enable bits |
| irq_prio_i | input | NIRQ*PRIO_W | Per-interrupt priority values, interrupt i at bits [i*PRIO_W +: PRIO_W] |
| mask_i | input | 1 | Global mask that holds back handler entry |
| exec_prio_i | input | PRIO_W+1 | Current execution priority; 2**PRIO_W in thread mode |
| sleep_o | output | 1 | Core asleep, gates instruction fetch |
| wake_o | output | 1 | One-cycle wake pulse |
| take_exc_o | output | 1 | A handler may be entered now |

## Verification
The two functions that can fall in the same cycle are the recording of an event and its use by a wait-for-event strobe. The bench drives send-event together with wait-for-event twice. Once the latch is already set, and the test expects a fall-through followed by another fall-through. Once the latch is clear, and the test expects exactly one cycle of sleep, a wake pulse, and a later strobe that sleeps again. Where a pending bit rises during sleep, the bench judges the wake by the sleep flag and the wake pulse one cycle after that edge.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int NIRQ   = 8,
  parameter int PRIO_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wfi_i,
  input  logic                   wfe_i,
  input  logic                   sev_i,
  input  logic                   exc_ret_thread_i,
  input  logic                   sleep_on_exit_i,
  input  logic                   send_ev_on_pend_i,
  input  logic [NIRQ-1:0]        irq_pend_i,
  input  logic [NIRQ-1:0]        irq_en_i,
  input  logic [NIRQ*PRIO_W-1:0] irq_prio_i,
  input  logic                   mask_i,
  input  logic [PRIO_W:0]        exec_prio_i,
  output logic                   sleep_o,
  output logic                   wake_o,
  output logic                   take_exc_o
);

  logic            sleep_q, wake_q, ev_q, by_event_q;
  logic [NIRQ-1:0] pend_q;
  logic            qual, ev_in, wake_cond;
  logic            go_wfi, go_wfe, fall_thru;

  always_comb begin
    qual = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (irq_pend_i[i] && irq_en_i[i] &&
          ({1'b0, irq_prio_i[i*PRIO_W +: PRIO_W]} < exec_prio_i))
        qual = 1'b1;
  end

  assign ev_in     = sev_i | (send_ev_on_pend_i & |(irq_pend_i & ~pend_q));
  assign wake_cond = qual | (by_event_q & (ev_q | ev_in));

  assign go_wfi    = ~sleep_q & (wfi_i | (exc_ret_thread_i & sleep_on_exit_i));
  assign go_wfe    = ~sleep_q & ~go_wfi & wfe_i & ~ev_q;
  assign fall_thru = ~sleep_q & ~go_wfi & wfe_i &  ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q    <= 1'b0;
      wake_q     <= 1'b0;
      ev_q       <= 1'b0;
      by_event_q <= 1'b0;
      pend_q     <= '0;
    end else begin
      pend_q <= irq_pend_i;
      wake_q <= 1'b0;
      if (sleep_q) begin
        if (wake_cond) begin
          sleep_q <= 1'b0;
          wake_q  <= 1'b1;
          ev_q    <= by_event_q ? 1'b0 : (ev_q | ev_in);
        end else begin
          ev_q    <= ev_q | ev_in;
        end
      end else begin
        if (go_wfi) begin
          sleep_q    <= 1'b1;
          by_event_q <= 1'b0;
        end else if (go_wfe) begin
          sleep_q    <= 1'b1;
          by_event_q <= 1'b1;
        end
        ev_q <= fall_thru ? ev_in : (ev_q | ev_in);
      end
    end
  end

  assign sleep_o    = sleep_q;
  assign wake_o     = wake_q;
  assign take_exc_o = ~sleep_q & qual & ~mask_i;

endmodule

module sleep_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wfi_i,
  input logic exc_ret_thread_i,
  input logic sleep_on_exit_i,
  input logic mask_i,
  input logic sleep_o,
  input logic wake_o,
  input logic take_exc_o
);

  // R2
  wfi_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && wfi_i) |=> sleep_o);

  // R10
  exit_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && exc_ret_thread_i && sleep_on_exit_i) |=> sleep_o);

  // R3
  wake_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!sleep_o && $past(sleep_o)));

  // R3
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R4
  no_take_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !take_exc_o);

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |-> !take_exc_o);

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wfi_i(wfi_i), .exc_ret_thread_i(exc_ret_thread_i),
  .sleep_on_exit_i(sleep_on_exit_i), .mask_i(mask_i), .sleep_o(sleep_o),
  .wake_o(wake_o), .take_exc_o(take_exc_o)
);

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
  localparam int NIRQ = 8;
  localparam int PW   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic wfi, wfe, sev, eret, soe, sop, msk;
  logic [NIRQ-1:0]    pend, en;
  logic [NIRQ*PW-1:0] prio;
  logic [PW:0]        xprio;
  logic sleep, wake, take;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(.NIRQ(NIRQ), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .sev_i(sev),
    .exc_ret_thread_i(eret), .sleep_on_exit_i(soe), .send_ev_on_pend_i(sop),
    .irq_pend_i(pend), .irq_en_i(en), .irq_prio_i(prio), .mask_i(msk),
    .exec_prio_i(xprio), .sleep_o(sleep), .wake_o(wake), .take_exc_o(take)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic set_prio(input int i, input int p);
    prio[i*PW +: PW] = p[PW-1:0];
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 0; wfi = 0; wfe = 0; sev = 0; eret = 0; soe = 0; sop = 0; msk = 0;
    pend = '0; en = '0; prio = '0; xprio = 4'd8;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic pulse_wfe(); wfe = 1; step(); wfe = 0; endtask

  task automatic t_reset();
    restart();
    chk("R1 sleep after reset", sleep, 0);
    chk("R1 wake after reset", wake, 0);
    chk("R1 take after reset", take, 0);
    pulse_wfe();
    chk("R1 first wfe sleeps", sleep, 1);
  endtask

  task automatic t_wfi();
    restart();
    wfi = 1; step(); wfi = 0;
    chk("R2 wfi enters", sleep, 1);
    step(); step();
    chk("R2 stays asleep", sleep, 1);
    en[3] = 1; set_prio(3, 2); pend[3] = 1; step();
    chk("R3 wake sleep low", sleep, 0);
    chk("R3 wake pulse", wake, 1);
    step();
    chk("R3 wake pulse single", wake, 0);
    chk("R4 take after wake", take, 1);
  endtask

  task automatic t_wfi_ignore();
    restart();
    sop = 1; xprio = 4'd4;
    wfi = 1; step(); wfi = 0;
    pend[1] = 1; step();
    chk("R3 disabled irq no wake", sleep, 1);
    en[2] = 1; set_prio(2, 5); pend[2] = 1; step();
    chk("R3 low urgency no wake", sleep, 1);
    chk("R3 no pulse", wake, 0);
    en[5] = 1; set_prio(5, 3); pend[5] = 1; step();
    chk("R3 urgent irq wakes", sleep, 0);
  endtask

  task automatic t_mask();
    restart();
    msk = 1;
    wfi = 1; step(); wfi = 0;
    en[0] = 1; set_prio(0, 1); pend[0] = 1; step();
    chk("R4 masked irq wakes", sleep, 0);
    chk("R4 masked wake pulse", wake, 1);
    chk("R4 entry held", take, 0);
    step();
    chk("R4 entry still held", take, 0);
    msk = 0; #1;
    chk("R4 entry after unmask", take, 1);
  endtask

  task automatic t_sev();
    restart();
    sev = 1; step(); sev = 0;
    pulse_wfe();
    chk("R5 wfe falls through", sleep, 0);
    step();
    chk("R5 still awake", sleep, 0);
    pulse_wfe();
    chk("R5 R6 second wfe sleeps", sleep, 1);
    en[4] = 1; set_prio(4, 0); pend[4] = 1; step();
    chk("R6 irq wakes wfe sleep", sleep, 0);
    chk("R6 wake pulse", wake, 1);
  endtask

  task automatic t_pend_event();
    restart();
    pend[0] = 1; step();
    sop = 1; step();
    pulse_wfe();
    chk("R7 wfe sleeps", sleep, 1);
    step(); step();
    chk("R7 old pending ignored", sleep, 1);
    pend[1] = 1; step();
    chk("R7 new pending wakes", sleep, 0);
    chk("R7 wake pulse", wake, 1);
    step();
    pulse_wfe();
    chk("R11 latch cleared on wake", sleep, 1);
    sop = 0; pend[2] = 1; step(); step();
    chk("R7 option off no wake", sleep, 1);
  endtask

  task automatic t_same_cycle_consume();
    restart();
    sev = 1; step(); sev = 0;
    wfe = 1; sev = 1; step(); wfe = 0; sev = 0;
    chk("R8 consuming wfe awake", sleep, 0);
    pulse_wfe();
    chk("R8 next wfe falls through", sleep, 0);
    step();
    pulse_wfe();
    chk("R8 then wfe sleeps", sleep, 1);
  endtask

  task automatic t_same_cycle_sleep();
    restart();
    wfe = 1; sev = 1; step(); wfe = 0; sev = 0;
    chk("R9 sleep one cycle", sleep, 1);
    step();
    chk("R9 woke next", sleep, 0);
    chk("R9 wake pulse", wake, 1);
    step();
    pulse_wfe();
    chk("R9 event consumed", sleep, 1);
  endtask

  task automatic t_exit();
    restart();
    eret = 1; step(); eret = 0;
    chk("R10 no option no sleep", sleep, 0);
    soe = 1; sop = 1; xprio = 4'd4;
    eret = 1; step(); eret = 0;
    chk("R10 exit sleeps", sleep, 1);
    pend[6] = 1; step(); step();
    chk("R10 new pending no wake", sleep, 1);
    en[7] = 1; set_prio(7, 2); pend[7] = 1; step();
    chk("R10 urgent irq wakes", sleep, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    t_reset();
    t_wfi();
    t_wfi_ignore();
    t_mask();
    t_sev();
    t_pend_event();
    t_same_cycle_consume();
    t_same_cycle_sleep();
    t_exit();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule